// File: doc/BRIEF.md
# Debug Target Reset and Link Resync Controller

This block sits between a debug probe's command logic and the target's reset pin and single-wire debug line. On request it pulls the target reset low for a fixed number of millisecond ticks, releases it, and then waits a bounded number of millisecond ticks for the sensed reset pin to return high. If the pin never rises, a failure flag is raised. If it rises, the block counts a settle window in microsecond ticks before it declares the debug line usable. The settle window is a parameter, and it must be longer than the 512-cycle soft-reset time of the debug line. That soft-reset time is 1280 us at 400 kHz.

The block can also resynchronise the debug line. It drives the line low for a fixed number of microsecond ticks, then releases it. It then measures how many fast-clock cycles the target holds the line low in its reply. The width is stored as a 16-bit count, and a two-bit speed code reports the outcome. The codes are 0 for no information, 1 when a sync reply was measured, 2 for a guessed speed and 3 for a speed supplied by the user. Codes 2 and 3 are reserved for logic outside this block. If no complete reply arrives within a bounded number of fast cycles, the width stays zero and the code stays 0.

Millisecond and microsecond ticks arrive as single-cycle strobes in the fast clock domain. Both sensed pins pass through synchronisers.

Top module: `dbg_reset_resync`

## Requirements
- R1: An accepted `rst_req` drives `rst_pin_drive` high starting with the next cycle. The drive stays high for exactly ASSERT_MS cycles in which `tick_ms` is high, counted from that next cycle, and then drops.
- R2: After the drive drops, the controller watches the sensed reset pin. If it does not read high before WAIT_MS `tick_ms` strobes have occurred, the sequence ends with `rst_fail`=1 and `link_ready`=0.
- R3: After the sensed reset pin reads high, the controller counts SETTLE_US `tick_us` strobes and then ends the sequence with `link_ready`=1 and `rst_fail`=0. SETTLE_US must exceed SOFT_RESET_US.
- R4: `link_oe` is high only while the sync request pulse is being driven, and `link_out` is always 0. At all other times the debug line is released.
- R5: An accepted `sync_req` holds `link_oe` high for exactly SYNC_REQ_US cycles in which `tick_us` is high.
- R6: After release, the line must first read high. When the target then holds the line low for L fast cycles and the reply ends within SYNC_TIMEOUT cycles of release, `sync_width` becomes L and `speed_status` becomes 1.
- R7: If no reply arrives, or the reply does not end within SYNC_TIMEOUT cycles of release, the measurement ends with `sync_width`=0 and `speed_status`=0 (no info).
- R8: An accepted sync request or an accepted reset request clears `sync_width` to 0 and `speed_status` to 0.
- R9: `rst_seen` is set by a falling edge on the sensed reset pin while no reset sequence is running. It is cleared when a reset request is accepted.
- R10: When `rst_req` and `sync_req` are high in the same cycle, the reset is taken and the sync request is dropped. A reset request accepted during a sync aborts the sync, releases the line and drops `sync_busy`.
- R11: A `sync_req` that arrives while `rst_busy` is high is ignored. A `rst_req` that arrives while `rst_busy` is high is also ignored.
- R12: After `rst_n` is asserted, every drive, busy and flag output is 0, `sync_width` is 0 and `speed_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| tick_us | input | 1 | One-cycle microsecond strobe |
| rst_req | input | 1 | Request a target reset sequence |
| sync_req | input | 1 | Request a link sync measurement |
| rst_pin_in | input | 1 | Sensed target reset pin level |
| link_pin_in | input | 1 | Sensed debug line level |
| rst_pin_drive | output | 1 | 1 = pull target reset low |
| link_oe | output | 1 | Debug line output enable |
| link_out | output | 1 | Debug line value when enabled (always 0) |
| rst_busy | output | 1 | Reset sequence running |
| rst_fail | output | 1 | Reset pin did not rise in time |
| link_ready | output | 1 | Settle window completed after reset |
| rst_seen | output | 1 | External reset activity observed |
| sync_busy | output | 1 | Sync request or measurement running |
| sync_width | output | 16 | Measured sync reply width in fast cycles |
| speed_status | output | 2 | Speed code: 0 none, 1 sync, 2 guessed, 3 user |

## Verification
The reset sequencer and the sync measurer compete for the target in two ways. A reset request and a sync request can arrive in the same cycle, and a reset request can arrive while the sync pulse is still being driven. The bench raises both requests on one edge. It then confirms that the line was never enabled during the whole reset sequence and that the earlier width was cleared. It also issues a reset request while the line is driven and checks, one cycle later, that the line is released, the sync is idle and the width is zero while the reset runs.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

    typedef enum logic [1:0] {
        SPD_NONE  = 2'd0,
        SPD_SYNC  = 2'd1,
        SPD_GUESS = 2'd2,
        SPD_USER  = 2'd3
    } speed_code_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HOLD,
        RS_RELEASE,
        RS_SETTLE
    } rst_state_e;

    typedef enum logic [2:0] {
        SY_IDLE,
        SY_DRIVE,
        SY_WAIT_HI,
        SY_WAIT_LO,
        SY_MEASURE
    } sync_state_e;

endpackage

// File: rtl/rsync_sync.sv
module rsync_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rsync_reset_seq.sv
module rsync_reset_seq
    import rsync_pkg::*;
#(
    parameter int ASSERT_MS = 100,
    parameter int WAIT_MS   = 300,
    parameter int SETTLE_US = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic tick_us,
    input  logic start,
    input  logic pin_s,
    output logic drive,
    output logic busy,
    output logic fail,
    output logic ready,
    output logic seen
);

    localparam int MAX_A = (ASSERT_MS > WAIT_MS) ? ASSERT_MS : WAIT_MS;
    localparam int MAX_C = (MAX_A > SETTLE_US) ? MAX_A : SETTLE_US;
    localparam int CW    = $clog2(MAX_C + 1);

    typedef struct packed {
        rst_state_e    st;
        logic [CW-1:0] cnt;
        logic          fail;
        logic          ready;
        logic          seen;
        logic          pin_prev;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d          = seq_q;
        seq_d.pin_prev = pin_s;
        unique case (seq_q.st)
            RS_IDLE: begin
                if (start) begin
                    seq_d.st    = RS_HOLD;
                    seq_d.cnt   = '0;
                    seq_d.fail  = 1'b0;
                    seq_d.ready = 1'b0;
                    seq_d.seen  = 1'b0;
                end else if (seq_q.pin_prev && !pin_s) begin
                    seq_d.seen = 1'b1;
                end
            end
            RS_HOLD: begin
                if (tick_ms) begin
                    if (seq_q.cnt == CW'(ASSERT_MS - 1)) begin
                        seq_d.st  = RS_RELEASE;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            RS_RELEASE: begin
                if (pin_s) begin
                    seq_d.st  = RS_SETTLE;
                    seq_d.cnt = '0;
                end else if (tick_ms) begin
                    if (seq_q.cnt == CW'(WAIT_MS - 1)) begin
                        seq_d.st   = RS_IDLE;
                        seq_d.cnt  = '0;
                        seq_d.fail = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            RS_SETTLE: begin
                if (tick_us) begin
                    if (seq_q.cnt == CW'(SETTLE_US - 1)) begin
                        seq_d.st    = RS_IDLE;
                        seq_d.cnt   = '0;
                        seq_d.ready = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: seq_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: RS_IDLE, cnt: '0, fail: 1'b0, ready: 1'b0,
                       seen: 1'b0, pin_prev: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign drive = (seq_q.st == RS_HOLD);
    assign busy  = (seq_q.st != RS_IDLE);
    assign fail  = seq_q.fail;
    assign ready = seq_q.ready;
    assign seen  = seq_q.seen;

endmodule

// File: rtl/rsync_sync_meas.sv
module rsync_sync_meas
    import rsync_pkg::*;
#(
    parameter int SYNC_REQ_US  = 350,
    parameter int SYNC_TIMEOUT = 60000,
    parameter int WIDTH_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic               start,
    input  logic               abort,
    input  logic               line_s,
    output logic               oe,
    output logic               busy,
    output logic [WIDTH_W-1:0] width,
    output logic [1:0]         speed
);

    localparam int UW = $clog2(SYNC_REQ_US + 1);
    localparam int TW = $clog2(SYNC_TIMEOUT + 1);

    typedef struct packed {
        sync_state_e        st;
        logic [UW-1:0]      ucnt;
        logic [TW-1:0]      tcnt;
        logic [WIDTH_W-1:0] wcnt;
        logic [WIDTH_W-1:0] width;
        speed_code_e        speed;
    } meas_t;

    meas_t m_d, m_q;
    logic  timed_out;

    assign timed_out = (m_q.tcnt == TW'(SYNC_TIMEOUT - 1));

    always_comb begin
        m_d = m_q;
        if (abort) begin
            m_d.st    = SY_IDLE;
            m_d.width = '0;
            m_d.speed = SPD_NONE;
        end else begin
            unique case (m_q.st)
                SY_IDLE: begin
                    if (start) begin
                        m_d.st    = SY_DRIVE;
                        m_d.ucnt  = '0;
                        m_d.width = '0;
                        m_d.speed = SPD_NONE;
                    end
                end
                SY_DRIVE: begin
                    if (tick_us) begin
                        if (m_q.ucnt == UW'(SYNC_REQ_US - 1)) begin
                            m_d.st   = SY_WAIT_HI;
                            m_d.tcnt = '0;
                        end else begin
                            m_d.ucnt = m_q.ucnt + 1'b1;
                        end
                    end
                end
                SY_WAIT_HI: begin
                    m_d.tcnt = m_q.tcnt + 1'b1;
                    if (line_s)         m_d.st = SY_WAIT_LO;
                    else if (timed_out) m_d.st = SY_IDLE;
                end
                SY_WAIT_LO: begin
                    m_d.tcnt = m_q.tcnt + 1'b1;
                    if (!line_s) begin
                        m_d.st   = SY_MEASURE;
                        m_d.wcnt = WIDTH_W'(1);
                    end else if (timed_out) begin
                        m_d.st = SY_IDLE;
                    end
                end
                SY_MEASURE: begin
                    m_d.tcnt = m_q.tcnt + 1'b1;
                    if (line_s) begin
                        m_d.st    = SY_IDLE;
                        m_d.width = m_q.wcnt;
                        m_d.speed = SPD_SYNC;
                    end else if (timed_out) begin
                        m_d.st = SY_IDLE;
                    end else begin
                        m_d.wcnt = m_q.wcnt + 1'b1;
                    end
                end
                default: m_d.st = SY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{st: SY_IDLE, ucnt: '0, tcnt: '0, wcnt: '0,
                     width: '0, speed: SPD_NONE};
        end else begin
            m_q <= m_d;
        end
    end

    assign oe    = (m_q.st == SY_DRIVE);
    assign busy  = (m_q.st != SY_IDLE);
    assign width = m_q.width;
    assign speed = m_q.speed;

endmodule

// File: rtl/dbg_reset_resync.sv
module dbg_reset_resync #(
    parameter int ASSERT_MS     = 100,
    parameter int WAIT_MS       = 300,
    parameter int SETTLE_US     = 3000,
    parameter int SOFT_RESET_US = 1280,
    parameter int SYNC_REQ_US   = 350,
    parameter int SYNC_TIMEOUT  = 60000,
    parameter int WIDTH_W       = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_ms,
    input  logic               tick_us,
    input  logic               rst_req,
    input  logic               sync_req,
    input  logic               rst_pin_in,
    input  logic               link_pin_in,
    output logic               rst_pin_drive,
    output logic               link_oe,
    output logic               link_out,
    output logic               rst_busy,
    output logic               rst_fail,
    output logic               link_ready,
    output logic               rst_seen,
    output logic               sync_busy,
    output logic [WIDTH_W-1:0] sync_width,
    output logic [1:0]         speed_status
);

    logic rst_pin_s, link_pin_s;
    logic rst_start, sync_start;

    rsync_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_rst_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(rst_pin_in), .dout(rst_pin_s)
    );

    rsync_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_link_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(link_pin_in), .dout(link_pin_s)
    );

    // reset wins over sync; neither is taken while a reset runs
    assign rst_start  = rst_req && !rst_busy;
    assign sync_start = sync_req && !rst_busy && !rst_req;

    rsync_reset_seq #(
        .ASSERT_MS(ASSERT_MS), .WAIT_MS(WAIT_MS), .SETTLE_US(SETTLE_US)
    ) i_reset_seq (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tick_us(tick_us),
        .start(rst_start), .pin_s(rst_pin_s), .drive(rst_pin_drive),
        .busy(rst_busy), .fail(rst_fail), .ready(link_ready), .seen(rst_seen)
    );

    rsync_sync_meas #(
        .SYNC_REQ_US(SYNC_REQ_US), .SYNC_TIMEOUT(SYNC_TIMEOUT), .WIDTH_W(WIDTH_W)
    ) i_sync_meas (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(sync_start),
        .abort(rst_start), .line_s(link_pin_s), .oe(link_oe), .busy(sync_busy),
        .width(sync_width), .speed(speed_status)
    );

    assign link_out = 1'b0;

endmodule

// File: rtl/rsync_checker.sv
module rsync_checker #(
    parameter int SETTLE_US     = 3000,
    parameter int SOFT_RESET_US = 1280,
    parameter int SYNC_TIMEOUT  = 60000,
    parameter int WIDTH_W       = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_req,
    input logic               rst_pin_drive,
    input logic               link_oe,
    input logic               rst_busy,
    input logic               rst_fail,
    input logic               link_ready,
    input logic               sync_busy,
    input logic [WIDTH_W-1:0] sync_width,
    input logic [1:0]         speed_status
);

    initial begin
        assert_settle_margin_R3: assert (SETTLE_US > SOFT_RESET_US)
            else $error("settle window not longer than soft reset");
        assert_timeout_fits_R6: assert (SYNC_TIMEOUT < (2 ** WIDTH_W))
            else $error("timeout exceeds width counter");
    end

    assert_drive_in_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_drive |-> rst_busy);

    assert_fail_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fail |-> !link_ready);

    assert_ready_after_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> $past(rst_busy));

    assert_oe_from_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_oe) |-> $past(sync_req));

    assert_width_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_status == 2'd1) |-> (sync_width != '0));

    assert_no_info_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_status == 2'd0) |-> (sync_width == '0));

    assert_busy_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_busy |-> (sync_width == '0 && speed_status == 2'd0));

    assert_oe_no_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        link_oe |-> !rst_busy);

endmodule

bind dbg_reset_resync rsync_checker #(
    .SETTLE_US(SETTLE_US), .SOFT_RESET_US(SOFT_RESET_US),
    .SYNC_TIMEOUT(SYNC_TIMEOUT), .WIDTH_W(WIDTH_W)
) i_rsync_checker (.*);

// File: tb/test_dbg_reset_resync.sv
`timescale 1ns/1ps
module test_dbg_reset_resync;

    localparam int A_MS = 4;
    localparam int W_MS = 6;
    localparam int S_US = 20;
    localparam int SOFT = 16;
    localparam int SQ_US = 10;
    localparam int TOUT = 400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_ms = 1'b0, tick_us = 1'b0, rst_req = 1'b0, sync_req = 1'b0;
    logic tgt_rst_level = 1'b1, tgt_link_low = 1'b0;
    logic rst_pin_in, link_pin_in;
    logic rst_pin_drive, link_oe, link_out, rst_busy, rst_fail, link_ready, rst_seen, sync_busy;
    logic [15:0] sync_width;
    logic [1:0]  speed_status;

    int checks = 0, fails = 0;
    int ms_drive = 0, ms_release = 0, us_settle = 0, us_oe = 0, oe_cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign rst_pin_in  = rst_pin_drive ? 1'b0 : tgt_rst_level;
    assign link_pin_in = link_oe ? link_out : !tgt_link_low;

    dbg_reset_resync #(
        .ASSERT_MS(A_MS), .WAIT_MS(W_MS), .SETTLE_US(S_US), .SOFT_RESET_US(SOFT),
        .SYNC_REQ_US(SQ_US), .SYNC_TIMEOUT(TOUT)
    ) i_dbg_reset_resync (.*);

    // tick generators: us every 5 cycles, ms every 50 cycles
    initial begin
        int uc = 0, mc = 0;
        forever begin
            @(negedge clk);
            tick_us = (uc == 4);
            tick_ms = (mc == 49);
            uc = (uc == 4) ? 0 : uc + 1;
            mc = (mc == 49) ? 0 : mc + 1;
        end
    end

    // monitor, samples just after the falling edge
    initial begin
        forever begin
            @(negedge clk); #1;
            if (tick_ms && rst_pin_drive) ms_drive++;
            if (tick_ms && rst_busy && !rst_pin_drive && !rst_pin_in) ms_release++;
            if (tick_us && rst_busy && !rst_pin_drive && rst_pin_in) us_settle++;
            if (tick_us && link_oe) us_oe++;
            if (link_oe) oe_cycles++;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_width(int dly, int len);
        if (len > 0 && dly + len + 6 < TOUT) return len;
        return 0;
    endfunction

    task automatic wait_rst_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); #1;
            if (!rst_busy) break;
        end
    endtask

    task automatic run_reset();
        @(negedge clk);
        ms_drive = 0; ms_release = 0; us_settle = 0;
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        wait_rst_idle();
    endtask

    task automatic do_sync(int dly, int len, string tag);
        int ew;
        ew = exp_width(dly, len);
        @(negedge clk);
        us_oe = 0;
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk); #1;
            if (!link_oe) break;
        end
        check(us_oe == SQ_US, {tag, " R5 pulse us ticks"}, us_oe, SQ_US);
        repeat (dly - 1) @(negedge clk);
        if (len > 0) begin
            tgt_link_low = 1'b1;
            repeat (len) @(negedge clk);
            tgt_link_low = 1'b0;
        end
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (!sync_busy) break;
        end
        check(sync_width == 16'(ew), {tag, " width"}, int'(sync_width), ew);
        check(speed_status == ((ew != 0) ? 2'd1 : 2'd0), {tag, " speed code"},
              int'(speed_status), (ew != 0) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R12 reset state
        check(!rst_pin_drive && !link_oe && !rst_busy && !sync_busy, "R12 idle outputs", 0, 0);
        check(!rst_fail && !link_ready && !rst_seen, "R12 flags", int'(rst_fail), 0);
        check(sync_width == 0 && speed_status == 0, "R12 width/status", int'(sync_width), 0);

        // R1 + R3 successful reset
        tgt_rst_level = 1'b1;
        run_reset();
        check(ms_drive == A_MS, "R1 assert ms ticks", ms_drive, A_MS);
        check(link_ready && !rst_fail, "R3 ready after settle", int'(link_ready), 1);
        check(us_settle == S_US || us_settle == S_US + 1, "R3 settle us ticks", us_settle, S_US);

        // R2 timeout path
        tgt_rst_level = 1'b0;
        run_reset();
        check(ms_drive == A_MS, "R1 assert ms ticks (fail run)", ms_drive, A_MS);
        check(ms_release == W_MS, "R2 wait ms ticks", ms_release, W_MS);
        check(rst_fail && !link_ready, "R2 failure flag", int'(rst_fail), 1);
        tgt_rst_level = 1'b1;
        run_reset();
        check(link_ready && !rst_fail, "R3 recovery after failure", int'(link_ready), 1);

        // R9 external reset activity
        check(!rst_seen, "R9 seen clear before", int'(rst_seen), 0);
        @(negedge clk); tgt_rst_level = 1'b0;
        repeat (5) @(negedge clk); tgt_rst_level = 1'b1;
        repeat (4) @(negedge clk); #1;
        check(rst_seen, "R9 seen set by external low", int'(rst_seen), 1);
        run_reset();
        check(!rst_seen, "R9 seen cleared by reset request", int'(rst_seen), 0);

        // R6 / R7 directed corners
        do_sync(3, 1, "R6 minimal reply");
        do_sync(5, 0, "R7 no reply");
        do_sync(4, 600, "R7 overlong reply");
        do_sync(2, 250, "R6 long reply");
        // R6 constrained random widths
        for (int k = 0; k < 6; k++) begin
            int d, l;
            d = 2 + int'($urandom_range(18));
            l = 1 + int'($urandom_range(199));
            do_sync(d, l, "R6 random reply");
        end

        // R10 simultaneous requests, R8 clear on reset
        @(negedge clk);
        oe_cycles = 0;
        rst_req = 1'b1; sync_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0; sync_req = 1'b0;
        #1;
        check(rst_busy && !sync_busy, "R10 reset wins tie", int'(sync_busy), 0);
        check(sync_width == 0 && speed_status == 0, "R8 reset clears result", int'(sync_width), 0);
        wait_rst_idle();
        check(oe_cycles == 0, "R10 line never driven in tie", oe_cycles, 0);
        check(link_ready, "R10 reset completed", int'(link_ready), 1);

        // R10 abort during sync, R11 sync ignored while reset busy
        do_sync(6, 40, "R6 before abort");
        @(negedge clk); sync_req = 1'b1;
        @(negedge clk); sync_req = 1'b0;
        repeat (3) @(negedge clk); #1;
        check(link_oe, "R4 line driven during pulse", int'(link_oe), 1);
        @(negedge clk); rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0; #1;
        check(!link_oe && !sync_busy, "R10 reset aborts sync", int'(link_oe), 0);
        check(sync_width == 0 && speed_status == 0, "R8 abort clears width", int'(sync_width), 0);
        @(negedge clk); sync_req = 1'b1;
        @(negedge clk); sync_req = 1'b0;
        repeat (3) @(negedge clk); #1;
        check(!sync_busy && !link_oe && rst_busy, "R11 sync ignored during reset", int'(sync_busy), 0);
        oe_cycles = 0;
        wait_rst_idle();
        check(oe_cycles == 0 && link_out == 1'b0, "R4 line released outside pulse", oe_cycles, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule